// File: doc/BRIEF.md
# Load Value Replication Queue

This block hands cached-load input values from a leading execution thread to a redundant trailing thread. The two roles are fixed in advance. Only the leading thread's loads read the data cache. At load commit the leading thread writes the returned value, tagged with its address, into a first-in first-out queue. When the trailing thread reaches the same load, it takes the value from the head of the queue and never touches the cache. Both copies therefore consume the same input, even if an I/O device or another processor writes that location between the two loads. The queue also lets the threads run apart in time, so the two accesses need not be paired at the cache.

As each entry is consumed, the trailing thread's own computed address is compared with the stored one. A difference means a transient fault hit one of the copies, and it sets a sticky fault flag. A full queue holds back the leading commit. An empty queue holds back the trailing load. A synchronous reset empties the queue and clears the flag.

Top module: `load_value_repl_queue`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `leadReady` is 1, `trailReady` is 0 and `faultFlag` is 0. Entries held before the reset are discarded.
- R2: When `trailReady` is 1, `trailData` shows the value of the oldest leading push that has not yet been consumed. A consume happens when `trailValid` and `trailReady` are both 1 at a rising clock edge. Values come out in push order.
- R3: `leadReady` is 0 exactly when the queue holds DEPTH entries. A push happens only when `leadValid` and `leadReady` are both 1 at a rising edge. A push offered while `leadReady` is 0 stores nothing and never appears on `trailData`.
- R4: `trailReady` is 0 exactly when the queue is empty. A trailing request made while it is 0 consumes nothing.
- R5: A push and a consume accepted at the same edge both take effect, and the occupancy stays the same.
- R6: An accepted consume whose `trailAddr` differs from the stored address sets `faultFlag` from the next cycle on. A consume with a matching address leaves the flag unchanged.
- R7: `faultFlag` stays at 1 through later matching consumes, pushes and idle cycles until a reset.
- R8: A value pushed into an empty queue is offered on `trailData`, with `trailReady` at 1, in the cycle after the push edge. There is no same-cycle bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| leadValid | input | 1 | Leading thread commits a load |
| leadAddr | input | ADDR_W | Address of the committed leading load |
| leadData | input | DATA_W | Value the cache returned for it |
| leadReady | output | 1 | Queue can accept a push |
| trailValid | input | 1 | Trailing thread requests its next load value |
| trailAddr | input | ADDR_W | Address the trailing thread computed |
| trailReady | output | 1 | Queue holds an entry for the trailing thread |
| trailData | output | DATA_W | Value at the head of the queue |
| faultFlag | output | 1 | Sticky address-mismatch indication |

## Verification
A leading push and a trailing consume can fall in the same cycle. The bench runs the queue at a small depth with arithmetic valid patterns that overlap the two requests at every occupancy from empty to full. At the two edges, full and empty, one side is held off while the other proceeds. A reference queue in the bench is updated only by the handshakes the requirements allow. Every cycle the bench compares both ready signals, the head value and the fault flag against that reference. A mismatching trailing address is injected during overlapping traffic to check that the flag is set and then held.

// File: rtl/lvq_pkg.sv
package lvq_pkg;
  // Strobes from control to datapath, one per accepted handshake
  typedef struct packed {
    logic push;
    logic pop;
  } lvq_strobe_t;
endpackage

// File: rtl/lvq_ctrl.sv
module lvq_ctrl
  import lvq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     leadValid,
  input  logic                     trailValid,
  output logic                     leadReady,
  output logic                     trailReady,
  output lvq_strobe_t              strb,
  output logic [$clog2(DEPTH)-1:0] wrPtr,
  output logic [$clog2(DEPTH)-1:0] rdPtr
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;

  assign leadReady  = (count != FULL_CNT);
  assign trailReady = (count != '0);
  assign strb.push  = leadValid && leadReady;
  assign strb.pop   = trailValid && trailReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R3
  push_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.push && !strb.pop) |=> (count == $past(count) + 1'b1));

  // R4
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pop && !strb.push) |=> (count == $past(count) - 1'b1));

  // R5
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pop && strb.push) |=> $stable(count));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (count == '0));
endmodule

// File: rtl/lvq_store.sv
module lvq_store
  import lvq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  lvq_strobe_t              strb,
  input  logic [$clog2(DEPTH)-1:0] wrPtr,
  input  logic [$clog2(DEPTH)-1:0] rdPtr,
  input  logic [ADDR_W-1:0]        leadAddr,
  input  logic [DATA_W-1:0]        leadData,
  input  logic [ADDR_W-1:0]        trailAddr,
  output logic [DATA_W-1:0]        trailData,
  output logic                     faultFlag
);
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic              addrMiss;

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrMem[wrPtr] <= leadAddr;
      dataMem[wrPtr] <= leadData;
    end
  end

  assign trailData = dataMem[rdPtr];
  assign addrMiss  = strb.pop && (addrMem[rdPtr] != trailAddr);

  always_ff @(posedge clk) begin
    if (rst)           faultFlag <= 1'b0;
    else if (addrMiss) faultFlag <= 1'b1;
  end

  // R6
  miss_sets_chk: assert property (@(posedge clk) disable iff (rst)
    addrMiss |=> faultFlag);

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    faultFlag |=> faultFlag);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.pop && !faultFlag) |=> !faultFlag);
endmodule

// File: rtl/load_value_repl_queue.sv
module load_value_repl_queue
  import lvq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              leadValid,
  input  logic [ADDR_W-1:0] leadAddr,
  input  logic [DATA_W-1:0] leadData,
  output logic              leadReady,
  input  logic              trailValid,
  input  logic [ADDR_W-1:0] trailAddr,
  output logic              trailReady,
  output logic [DATA_W-1:0] trailData,
  output logic              faultFlag
);
  localparam int PTR_W = $clog2(DEPTH);

  lvq_strobe_t      strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  lvq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .leadValid  (leadValid),
    .trailValid (trailValid),
    .leadReady  (leadReady),
    .trailReady (trailReady),
    .strb       (strb),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr)
  );

  lvq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .leadAddr  (leadAddr),
    .leadData  (leadData),
    .trailAddr (trailAddr),
    .trailData (trailData),
    .faultFlag (faultFlag)
  );
endmodule

// File: tb/load_value_repl_queue_bench.sv
module load_value_repl_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int AW = 16;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          leadValid = 1'b0;
  logic [AW-1:0] leadAddr = '0;
  logic [DW-1:0] leadData = '0;
  logic          leadReady;
  logic          trailValid = 1'b0;
  logic [AW-1:0] trailAddr = '0;
  logic          trailReady;
  logic [DW-1:0] trailData;
  logic          faultFlag;

  int nChk = 0;
  int nErr = 0;
  int k = 0;
  int cyc = 0;

  // reference queue
  logic [AW-1:0] ma [D];
  logic [DW-1:0] md [D];
  int  mh = 0;
  int  mc = 0;
  bit  mf = 1'b0;

  load_value_repl_queue #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_load_value_repl_queue (
    .clk(clk), .rst(rst),
    .leadValid(leadValid), .leadAddr(leadAddr), .leadData(leadData), .leadReady(leadReady),
    .trailValid(trailValid), .trailAddr(trailAddr), .trailReady(trailReady),
    .trailData(trailData), .faultFlag(faultFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; leadValid = 1'b0; trailValid = 1'b0;
    @(negedge clk);
    // R1 during reset
    chk(leadReady == 1'b1, "R1 leadReady in reset", DW'(leadReady), 1);
    chk(trailReady == 1'b0, "R1 trailReady in reset", DW'(trailReady), 0);
    chk(faultFlag == 1'b0, "R1 faultFlag in reset", DW'(faultFlag), 0);
    rst = 1'b0;
    mh = 0; mc = 0; mf = 1'b0;
  endtask

  // One cycle: drive after the falling edge, compare, then follow the rising edge
  task automatic step(input bit pv, input bit tv, input bit bad);
    bit doPush, doPop;
    int tail;
    @(negedge clk);
    leadValid  = pv;
    leadAddr   = AW'(k * 8 + 16'h0100);
    leadData   = {32'(k) * 32'h9E3779B9, 32'(k) ^ 32'h5A5A0000};
    trailValid = tv;
    trailAddr  = (mc > 0) ? (ma[mh] ^ AW'(bad)) : 16'hFFFF;
    #1;
    chk(leadReady == (mc < D), "R3 leadReady vs occupancy", DW'(leadReady), DW'(mc < D));
    chk(trailReady == (mc > 0), "R4/R8 trailReady vs occupancy", DW'(trailReady), DW'(mc > 0));
    if (mc > 0) chk(trailData == md[mh], "R2 head value", trailData, md[mh]);
    chk(faultFlag == mf, "R6/R7 faultFlag", DW'(faultFlag), DW'(mf));
    doPush = pv && (mc < D);
    doPop  = tv && (mc > 0);
    tail = (mh + mc) % D;
    @(posedge clk);
    if (doPush) begin
      ma[tail] = leadAddr;
      md[tail] = leadData;
      mc++;
    end
    if (doPop) begin
      if (ma[mh] != trailAddr) mf = 1'b1;
      mh = (mh + 1) % D;
      mc--;
    end
    k++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nErr++; nChk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nErr, nChk);
        $finish;
      end
    end
  end

  initial begin
    doReset();
    // R1 first cycle after release
    #1;
    chk(leadReady && !trailReady && !faultFlag, "R1 state after release",
        DW'({leadReady, trailReady, faultFlag}), 64'h4);

    // R8: single push into empty queue, visible next cycle
    step(1, 0, 0);
    step(0, 0, 0);
    // R3: fill past full; offers while full must be dropped
    for (int i = 0; i < D + 3; i++) step(1, 0, 0);
    // R2/R4: drain and keep requesting while empty
    for (int i = 0; i < D + 3; i++) step(0, 1, 0);

    // R5: overlapping push/consume swept over every occupancy
    for (int occ = 0; occ <= D; occ++) begin
      doReset();
      for (int i = 0; i < occ; i++) step(1, 0, 0);
      for (int i = 0; i < 6; i++) step(1, 1, 0);
      for (int i = 0; i < D + 1; i++) step(0, 1, 0);
    end

    // mixed arithmetic patterns, all four request combinations
    doReset();
    for (int c = 0; c < 400; c++)
      step(((c * 5 + 1) % 7) < 4, ((c * 3) % 5) < 3, 1'b0);

    // R6: mismatch during overlapping traffic; R7: flag then holds
    doReset();
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(1, 1, 0);
    step(0, 0, 0);
    step(1, 1, 1);
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 1, 0);
    step(0, 0, 0);
    chk(mf == 1'b1 && faultFlag == 1'b1, "R7 flag held", DW'(faultFlag), 1);

    // R1/R7: reset clears the flag and discards entries
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    doReset();
    #1;
    chk(!trailReady && !faultFlag, "R1 reset empties and clears",
        DW'({trailReady, faultFlag}), 0);
    for (int i = 0; i < 6; i++) step(i < 2, i >= 2, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule